// File: doc/BRIEF.md
# Speculative reorder buffer

The block keeps instructions in a circular buffer in the order they were issued, so that results can be produced out of order and retired in order. On issue, an instruction takes the slot at the tail pointer, and that slot number becomes the tag for its result. Issue stalls while every slot is taken. Execution units, which the bench models, return results on a tagged write-back port. A waiting consumer can read a finished result by tag before that result commits.

When the head slot holds a completed entry, it retires in the same cycle. The entry kind decides what happens:

- A register operation writes the register file.
- A store performs its memory write.
- A branch resolves.

A branch that turns out to be mispredicted requests a redirect and discards every younger slot. An exception reported with a result is only recorded at write-back. It is raised when that entry reaches the head, and it then discards the entry and everything younger.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `iss_ready_o` is 1 and `iss_tag_o` is 0. `rf_we_o`, `mem_we_o`, `redirect_o`, `trap_o` and `flush_o` are 0. `rd_ready_o` is 0 for every tag.
- R2: An accepted issue takes the slot given by `iss_tag_o`. Tags advance by one per issue, modulo DEPTH. `iss_ready_o` is 0 while DEPTH entries are held and the head is not retiring.
- R3: A write-back with a tag sets that slot ready and stores its value. From the next cycle until the slot retires, `rd_ready_o` is 1 and `rd_value_o` shows that value when `rd_tag_i` selects the slot.
- R4: Only the oldest entry retires, and only once it is ready. Ready entries behind an unready head produce no commit output.
- R5: When a ready register operation (kind 2'b00) is at the head, `rf_we_o` is 1 in that cycle, with `rf_addr_o` set to its destination and `rf_data_o` set to its value. The slot is then freed.
- R6: When a ready store (kind 2'b01) is at the head, `mem_we_o` is 1, with `mem_addr_o` set to its destination and `mem_data_o` set to its value. No register write occurs.
- R7: A branch (kind 2'b10) whose write-back had `wb_mispred_i` at 0 retires with no register write, no memory write and no flush.
- R8: A branch whose write-back had `wb_mispred_i` at 1 retires with `redirect_o` and `flush_o` at 1 and `target_o` set to its value. All younger entries are discarded without committing. The next issue tag is the branch slot plus one.
- R9: An entry written back with `wb_exc_i` at 1 commits nothing. When it reaches the head, `trap_o` and `flush_o` are 1. It and all younger entries are discarded, and the next issue tag is its slot plus one.
- R10: A write-back to a slot that is not allocated (never issued, or discarded by a flush) has no effect. A later issue into that slot starts not ready.
- R11: When the buffer is full and the head retires in a cycle, an issue in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_kind_i | input | 2 | Entry kind: 00 register op, 01 store, 10 branch |
| iss_dest_i | input | DEST_W | Register number or memory address |
| iss_ready_o | output | 1 | A slot is available this cycle |
| iss_tag_o | output | TAG_W | Slot assigned to the issuing instruction |
| wb_valid_i | input | 1 | Result write-back |
| wb_tag_i | input | TAG_W | Slot being written |
| wb_value_i | input | DATA_W | Result, store data or branch target |
| wb_exc_i | input | 1 | Instruction raised an exception |
| wb_mispred_i | input | 1 | Branch was mispredicted |
| rd_tag_i | input | TAG_W | Operand lookup tag |
| rd_ready_o | output | 1 | Looked-up slot holds a result |
| rd_value_o | output | DATA_W | Looked-up result |
| rf_we_o | output | 1 | Register file write |
| rf_addr_o | output | DEST_W | Register number |
| rf_data_o | output | DATA_W | Register data |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | DEST_W | Memory address |
| mem_data_o | output | DATA_W | Memory data |
| flush_o | output | 1 | Younger entries discarded this cycle |
| redirect_o | output | 1 | Mispredicted branch retired |
| trap_o | output | 1 | Excepting entry reached the head |
| target_o | output | DATA_W | Corrected fetch target |

## Verification
The bench fills the buffer and writes results back in reverse order. A design that retires out of order, or lets a ready younger entry pass an unready head, would log register writes in the wrong order or too early. A sweep of every occupancy from one to DEPTH, with tags carried across wrap-around, catches pointer arithmetic that breaks modulo DEPTH.

Flush scenarios check several failure modes:
- Younger, already-ready entries must never reach the register file or memory.
- The tail must restart just past the flushing slot.
- A late write-back to a discarded slot must not make a later occupant of that slot look ready.

The bench also checks that an issue is accepted while a full buffer retires its head. A design that stalls there would drop that instruction's tag.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } kind_e;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             flush_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      // flushing entry retires, everything younger is dropped
      head_q <= step(head_q);
      tail_q <= step(head_q);
      cnt_q  <= '0;
    end else begin
      if (retire_i) head_q <= step(head_q);
      if (alloc_i)  tail_q <= step(tail_q);
      unique case ({alloc_i, retire_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R8
  AST_RETIRE_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |-> !empty_o); // R4
  AST_FULL_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && full_o) |-> retire_i); // R11
endmodule

// File: rtl/rob_slots.sv
module rob_slots
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 8,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  alloc_idx_i,
  input  kind_e             alloc_kind_i,
  input  logic [DEST_W-1:0] alloc_dest_i,
  input  logic              wb_valid_i,
  input  logic [TAG_W-1:0]  wb_idx_i,
  input  logic [DATA_W-1:0] wb_value_i,
  input  logic              wb_exc_i,
  input  logic              wb_mispred_i,
  input  logic              retire_i,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  head_idx_i,
  input  logic [TAG_W-1:0]  rd_idx_i,
  output logic              head_valid_o,
  output logic              head_ready_o,
  output kind_e             head_kind_o,
  output logic [DEST_W-1:0] head_dest_o,
  output logic [DATA_W-1:0] head_value_o,
  output logic              head_exc_o,
  output logic              head_mispred_o,
  output logic              rd_ready_o,
  output logic [DATA_W-1:0] rd_value_o
);
  logic [DEPTH-1:0]  valid_q, ready_q, exc_q, mis_q;
  kind_e             kind_q  [DEPTH];
  logic [DEST_W-1:0] dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ready_q <= '0;
      exc_q   <= '0;
      mis_q   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i]  <= KIND_REG;
        dest_q[i]  <= '0;
        value_q[i] <= '0;
      end
    end else if (flush_i) begin
      valid_q <= '0;
      ready_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_i && alloc_idx_i == TAG_W'(i)) begin
          // reuse of a retiring slot: allocation wins
          valid_q[i] <= 1'b1;
          ready_q[i] <= 1'b0;
          exc_q[i]   <= 1'b0;
          mis_q[i]   <= 1'b0;
          kind_q[i]  <= alloc_kind_i;
          dest_q[i]  <= alloc_dest_i;
        end else if (retire_i && head_idx_i == TAG_W'(i)) begin
          valid_q[i] <= 1'b0;
          ready_q[i] <= 1'b0;
        end else if (wb_valid_i && wb_idx_i == TAG_W'(i) && valid_q[i]) begin
          ready_q[i] <= 1'b1;
          value_q[i] <= wb_value_i;
          exc_q[i]   <= wb_exc_i;
          mis_q[i]   <= wb_mispred_i;
        end
      end
    end
  end

  assign head_valid_o   = valid_q[head_idx_i];
  assign head_ready_o   = ready_q[head_idx_i];
  assign head_kind_o    = kind_q[head_idx_i];
  assign head_dest_o    = dest_q[head_idx_i];
  assign head_value_o   = value_q[head_idx_i];
  assign head_exc_o     = exc_q[head_idx_i];
  assign head_mispred_o = mis_q[head_idx_i];
  assign rd_ready_o     = ready_q[rd_idx_i];
  assign rd_value_o     = value_q[rd_idx_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    AST_READY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_q[g] |-> valid_q[g]); // R3
  end

  AST_STALE_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && !valid_q[wb_idx_i]) |=> !ready_q[$past(wb_idx_i)]); // R10
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 8,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [1:0]        iss_kind_i,
  input  logic [DEST_W-1:0] iss_dest_i,
  output logic              iss_ready_o,
  output logic [TAG_W-1:0]  iss_tag_o,
  input  logic              wb_valid_i,
  input  logic [TAG_W-1:0]  wb_tag_i,
  input  logic [DATA_W-1:0] wb_value_i,
  input  logic              wb_exc_i,
  input  logic              wb_mispred_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              rd_ready_o,
  output logic [DATA_W-1:0] rd_value_o,
  output logic              rf_we_o,
  output logic [DEST_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_data_o,
  output logic              mem_we_o,
  output logic [DEST_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              flush_o,
  output logic              redirect_o,
  output logic              trap_o,
  output logic [DATA_W-1:0] target_o
);
  logic [TAG_W-1:0]  head, tail;
  logic              full, empty;
  logic              alloc, retire, flush;
  logic              h_valid, h_ready, h_exc, h_mis;
  kind_e             h_kind;
  logic [DEST_W-1:0] h_dest;
  logic [DATA_W-1:0] h_value;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alloc_i  (alloc),
    .retire_i (retire),
    .flush_i  (flush),
    .head_o   (head),
    .tail_o   (tail),
    .full_o   (full),
    .empty_o  (empty)
  );

  rob_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_slots (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .alloc_i        (alloc),
    .alloc_idx_i    (tail),
    .alloc_kind_i   (kind_e'(iss_kind_i)),
    .alloc_dest_i   (iss_dest_i),
    .wb_valid_i     (wb_valid_i),
    .wb_idx_i       (wb_tag_i),
    .wb_value_i     (wb_value_i),
    .wb_exc_i       (wb_exc_i),
    .wb_mispred_i   (wb_mispred_i),
    .retire_i       (retire),
    .flush_i        (flush),
    .head_idx_i     (head),
    .rd_idx_i       (rd_tag_i),
    .head_valid_o   (h_valid),
    .head_ready_o   (h_ready),
    .head_kind_o    (h_kind),
    .head_dest_o    (h_dest),
    .head_value_o   (h_value),
    .head_exc_o     (h_exc),
    .head_mispred_o (h_mis),
    .rd_ready_o     (rd_ready_o),
    .rd_value_o     (rd_value_o)
  );

  always_comb begin
    retire     = h_valid && h_ready;
    trap_o     = retire && h_exc;
    redirect_o = retire && !h_exc && h_kind == KIND_BRANCH && h_mis;
    rf_we_o    = retire && !h_exc && h_kind == KIND_REG;
    mem_we_o   = retire && !h_exc && h_kind == KIND_STORE;
    flush      = trap_o || redirect_o;
    // no allocation during a flush: the tail is being rewound
    iss_ready_o = (!full || retire) && !flush;
    alloc       = iss_valid_i && iss_ready_o;
  end

  assign flush_o    = flush;
  assign iss_tag_o  = tail;
  assign rf_addr_o  = h_dest;
  assign rf_data_o  = h_value;
  assign mem_addr_o = h_dest;
  assign mem_data_o = h_value;
  assign target_o   = h_value;

  AST_TRAP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (!rf_we_o && !mem_we_o)); // R9
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, mem_we_o, redirect_o, trap_o})); // R4
  AST_NO_COMMIT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !(rf_we_o || mem_we_o || flush_o)); // R4
  AST_REDIRECT_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> (iss_tag_o == (($past(head) == TAG_W'(DEPTH - 1)) ? '0 : $past(head) + 1'b1))); // R8
endmodule

// File: tb/tb_rob_core.sv
module tb_rob_core;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int DEST_W = 8;
  localparam int TAG_W  = 3;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0; logic [1:0] iss_kind = 0; logic [DEST_W-1:0] iss_dest = 0;
  logic iss_ready; logic [TAG_W-1:0] iss_tag;
  logic wb_valid = 0; logic [TAG_W-1:0] wb_tag = 0; logic [DATA_W-1:0] wb_value = 0;
  logic wb_exc = 0, wb_mis = 0;
  logic [TAG_W-1:0] rd_tag = 0; logic rd_ready; logic [DATA_W-1:0] rd_value;
  logic rf_we, mem_we, flush, redirect, trap;
  logic [DEST_W-1:0] rf_addr, mem_addr;
  logic [DATA_W-1:0] rf_data, mem_data, target;

  always #10 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .iss_valid_i(iss_valid), .iss_kind_i(iss_kind), .iss_dest_i(iss_dest),
    .iss_ready_o(iss_ready), .iss_tag_o(iss_tag),
    .wb_valid_i(wb_valid), .wb_tag_i(wb_tag), .wb_value_i(wb_value),
    .wb_exc_i(wb_exc), .wb_mispred_i(wb_mis),
    .rd_tag_i(rd_tag), .rd_ready_o(rd_ready), .rd_value_o(rd_value),
    .rf_we_o(rf_we), .rf_addr_o(rf_addr), .rf_data_o(rf_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .flush_o(flush), .redirect_o(redirect), .trap_o(trap), .target_o(target)
  );

  int checks = 0, errors = 0;
  int exp_tail = 0;
  int rf_n = 0, mem_n = 0, redir_n = 0, trap_n = 0;
  int rf_a [256]; int rf_d [256];
  int mem_a [64]; int mem_d [64];
  int last_target = 0;

  // commit monitor, mid-cycle
  always @(negedge clk) if (rst_n) begin
    if (rf_we)  begin rf_a[rf_n] = int'(rf_addr); rf_d[rf_n] = int'(rf_data); rf_n++; end
    if (mem_we) begin mem_a[mem_n] = int'(mem_addr); mem_d[mem_n] = int'(mem_data); mem_n++; end
    if (redirect) begin redir_n++; last_target = int'(target); end
    if (trap) trap_n++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic issue(input int kind, input int dest, output int tag);
    iss_valid = 1; iss_kind = 2'(kind); iss_dest = DEST_W'(dest);
    #1;
    chk(iss_ready === 1'b1, "R2 issue accepted", iss_ready, 1);
    chk(int'(iss_tag) == exp_tail, "R2 issue tag", iss_tag, exp_tail);
    tag = exp_tail;
    tick();
    iss_valid = 0;
    exp_tail = (exp_tail + 1) % DEPTH;
  endtask

  task automatic wb(input int tag, input int val, input bit exc, input bit mis);
    wb_valid = 1; wb_tag = TAG_W'(tag); wb_value = DATA_W'(val); wb_exc = exc; wb_mis = mis;
    tick();
    wb_valid = 0; wb_exc = 0; wb_mis = 0;
  endtask

  int t, t0, tb, ta, tbb, b0, m0, r0, x0;
  int tags [8];

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #35; rst_n = 1; #1;
    // R1 reset state
    chk(iss_ready === 1'b1, "R1 ready", iss_ready, 1);
    chk(iss_tag == 0, "R1 tag", iss_tag, 0);
    chk({rf_we, mem_we, redirect, trap, flush} == 5'b0, "R1 commit idle",
        {rf_we, mem_we, redirect, trap, flush}, 0);
    for (int k = 0; k < DEPTH; k++) begin
      rd_tag = TAG_W'(k); #1;
      chk(rd_ready === 1'b0, "R1 rd not ready", rd_ready, 0);
    end
    tick();

    // fill, reverse write-back, in-order drain
    b0 = rf_n;
    for (int k = 0; k < DEPTH; k++) issue(0, k + 1, t);
    #1; chk(iss_ready === 1'b0, "R2 full stalls", iss_ready, 0);
    for (int k = DEPTH - 1; k >= 1; k--) wb(k, 100 + k, 0, 0);
    tick(); tick();
    chk(rf_n == b0, "R4 head not ready blocks commit", rf_n - b0, 0);
    rd_tag = 3; #1;
    chk(rd_ready === 1'b1, "R3 rd ready", rd_ready, 1);
    chk(rd_value == 103, "R3 rd value", rd_value, 103);
    wb(0, 100, 0, 0);
    repeat (DEPTH + 2) tick();
    chk(rf_n == b0 + DEPTH, "R5 commit count", rf_n - b0, DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      chk(rf_a[b0 + k] == k + 1, "R5 rf addr order", rf_a[b0 + k], k + 1);
      chk(rf_d[b0 + k] == 100 + k, "R5 rf data order", rf_d[b0 + k], 100 + k);
    end
    chk(int'(iss_tag) == exp_tail, "R2 tag wraps", iss_tag, exp_tail);

    // R11: issue while full and retiring
    b0 = rf_n;
    for (int k = 0; k < DEPTH; k++) begin issue(0, 20 + k, t); tags[k] = t; end
    #1; chk(iss_ready === 1'b0, "R2 full again", iss_ready, 0);
    wb(tags[0], 7, 0, 0);
    chk(iss_ready === 1'b1, "R11 ready while full and retiring", iss_ready, 1);
    issue(0, 30, t0);
    chk(t0 == tags[0], "R11 reuses head slot", t0, tags[0]);
    for (int k = 1; k < DEPTH; k++) wb(tags[k], 8 + k, 0, 0);
    wb(t0, 99, 0, 0);
    repeat (DEPTH + 3) tick();
    chk(rf_n == b0 + DEPTH + 1, "R11 commit count", rf_n - b0, DEPTH + 1);
    chk(rf_a[b0 + DEPTH] == 30 && rf_d[b0 + DEPTH] == 99, "R11 late entry committed",
        rf_d[b0 + DEPTH], 99);

    // R6 store
    b0 = rf_n; m0 = mem_n;
    issue(1, 8'h2A, t);
    wb(t, 32'h55, 0, 0);
    tick(); tick();
    chk(mem_n == m0 + 1, "R6 store writes", mem_n - m0, 1);
    chk(mem_a[m0] == 8'h2A && mem_d[m0] == 32'h55, "R6 store addr/data", mem_d[m0], 32'h55);
    chk(rf_n == b0, "R6 no rf write", rf_n - b0, 0);

    // R7 correctly predicted branch
    b0 = rf_n; r0 = redir_n; m0 = mem_n;
    issue(2, 0, tb); issue(0, 5, t);
    wb(t, 9, 0, 0); wb(tb, 32'h40, 0, 0);
    repeat (3) tick();
    chk(redir_n == r0, "R7 no redirect", redir_n - r0, 0);
    chk(mem_n == m0, "R7 no mem write", mem_n - m0, 0);
    chk(rf_n == b0 + 1 && rf_a[b0] == 5 && rf_d[b0] == 9, "R7 younger commits", rf_n - b0, 1);

    // R8 mispredicted branch, R10 stale write-back
    b0 = rf_n; r0 = redir_n; m0 = mem_n;
    issue(2, 0, tb); issue(0, 6, ta); issue(1, 7, tbb);
    wb(ta, 1, 0, 0); wb(tbb, 2, 0, 0);
    wb(tb, 32'h1234, 0, 1);
    tick(); tick();
    chk(redir_n == r0 + 1, "R8 redirect", redir_n - r0, 1);
    chk(last_target == 32'h1234, "R8 target", last_target, 32'h1234);
    chk(rf_n == b0 && mem_n == m0, "R8 younger squashed", rf_n - b0 + mem_n - m0, 0);
    exp_tail = (tb + 1) % DEPTH;
    chk(int'(iss_tag) == exp_tail, "R8 tail rewound", iss_tag, exp_tail);
    rd_tag = TAG_W'(ta); #1;
    chk(rd_ready === 1'b0, "R8 squashed slot not ready", rd_ready, 0);
    wb((tb + 2) % DEPTH, 77, 0, 0);
    rd_tag = TAG_W'((tb + 2) % DEPTH); #1;
    chk(rd_ready === 1'b0, "R10 stale wb ignored", rd_ready, 0);
    issue(0, 40, ta); issue(0, 41, tbb);
    rd_tag = TAG_W'(tbb); #1;
    chk(rd_ready === 1'b0, "R10 reissued slot starts not ready", rd_ready, 0);
    wb(ta, 50, 0, 0); wb(tbb, 51, 0, 0);
    repeat (3) tick();
    chk(rf_n == b0 + 2 && rf_d[b0 + 1] == 51, "R10 reissued entries commit", rf_n - b0, 2);

    // R9 exception at head
    b0 = rf_n; x0 = trap_n; r0 = redir_n;
    issue(0, 11, ta); issue(0, 12, tbb);
    wb(tbb, 3, 0, 0);
    tick(); tick();
    chk(trap_n == x0 && rf_n == b0, "R9 nothing before head done", rf_n - b0, 0);
    wb(ta, 4, 1, 0);
    tick(); tick();
    chk(trap_n == x0 + 1, "R9 trap raised", trap_n - x0, 1);
    chk(rf_n == b0, "R9 no rf write", rf_n - b0, 0);
    chk(redir_n == r0, "R9 no redirect", redir_n - r0, 0);
    exp_tail = (ta + 1) % DEPTH;
    chk(int'(iss_tag) == exp_tail, "R9 tail rewound", iss_tag, exp_tail);

    // sweep of occupancies, reverse write-back
    for (int n = 1; n <= DEPTH; n++) begin
      b0 = rf_n;
      for (int k = 0; k < n; k++) begin issue(0, n * 16 + k, t); tags[k] = t; end
      for (int k = n - 1; k >= 0; k--) wb(tags[k], n * 256 + k, 0, 0);
      repeat (n + 3) tick();
      chk(rf_n == b0 + n, "R4 sweep count", rf_n - b0, n);
      for (int k = 0; k < n; k++)
        chk(rf_a[b0 + k] == n * 16 + k && rf_d[b0 + k] == n * 256 + k,
            "R5 sweep order", rf_d[b0 + k], n * 256 + k);
      chk(int'(iss_tag) == exp_tail, "R2 sweep tag", iss_tag, exp_tail);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule